// File: doc/BRIEF.md
# Scan-Gated Pipelined Reset Fan-Out

This block takes one raw active-low reset and fans it out to several units. The raw reset clears a two-flop synchronizer asynchronously. Once released, the synchronizer picks up a constant high, so its output deasserts on a clock edge. Each unit branch then has its own pipeline of repeater flip-flops after the synchronizer. The release edge therefore travels to distant units one register hop per clock and can run at the full functional rate. The raw reset also clears every repeater asynchronously, so assertion reaches all units at once without waiting for a clock.

Each branch output drives the active-low asynchronous reset pins of a unit's flops. The output is the last repeater of the branch, combined with scan enable. While scan enable is high, every output is pinned inactive (high), so shifting never disturbs the units. While scan enable is low, the repeater value passes straight through, so reset paths can toggle at speed during capture.

All synchronizer and repeater flops are mux-D scan cells. They form one serial chain, in this order: the two synchronizer flops, then every repeater in branch order, stage 0 first. The chain ends at a single scan-out port. `NUM_UNITS` sets the number of branches and `DEPTH` sets the repeater stages per branch.

Top module: `reset_fanout`

## Requirements
- R1: After `rstInN` rises with `scanEn` low, the synchronizer output goes high at the second rising clock edge, and no unit output rises before the edge after that.
- R2: While `rstInN` is low and `scanEn` is low, every bit of `unitRstN` is 0, and this takes effect as soon as `rstInN` falls, with no clock edge needed.
- R3: While `scanEn` is 1, every bit of `unitRstN` is 1, whatever the repeater contents and whatever the level of `rstInN`.
- R4: In functional mode, every bit of `unitRstN` rises together after rising edge number 2 + `DEPTH`, counted from the release of `rstInN`, and stays low after every earlier edge.
- R5: With `scanEn` high, the flops form one chain of 2 + `NUM_UNITS`*`DEPTH` cells. Chain position 0 is the first synchronizer flop and position 1 the second. Branch b stage k sits at position 2 + b*`DEPTH` + k. Bit i of `scanIn` appears on `scanOut` after rising edge i + 2 + `NUM_UNITS`*`DEPTH` - 1.
- R6: With `scanEn` low, `unitRstN[b]` equals the last repeater of branch b, at chain position 2 + b*`DEPTH` + `DEPTH` - 1. On a capture edge each repeater loads its predecessor in the branch, and stage 0 loads the second synchronizer flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional and scan clock |
| rstInN | input | 1 | Raw reset, active low, asynchronous assertion |
| scanEn | input | 1 | 1 = shift (outputs held inactive), 0 = capture or functional |
| scanIn | input | 1 | Serial scan data into chain position 0 |
| unitRstN | output | NUM_UNITS | Gated active-low reset per unit branch |
| scanOut | output | 1 | Serial scan data from the last chain cell |

## Verification
The release is tried at repeated reset cycles. Edge-by-edge sampling separates a pipeline that is one stage short or long from a correct one. It also separates a missing synchronizer stage from a missing repeater. The reset is dropped in mid-cycle and the outputs are sampled before any edge, which tells an asynchronous repeater reset apart from one that waits for a clock. Three distinct shift patterns check the chain order and length. With the chain preloaded, one capture cycle shows the pass-through during capture and the functional next-state of each repeater. Shift is also tried with the raw reset held low, to show that scan gating overrides the reset.

// File: rtl/reset_fanout_pkg.sv
package reset_fanout_pkg;
  // Strobes from the mode control to the reset datapath
  typedef struct packed {
    logic shiftSel;      // select serial scan source into every cell
    logic holdInactive;  // force every unit reset output high
  } rfStrobes_t;
endpackage

// File: rtl/reset_fanout_ctrl.sv
module reset_fanout_ctrl
  import reset_fanout_pkg::*;
(
  input  logic       scanEn,
  output rfStrobes_t strobes
);
  always_comb begin
    strobes.shiftSel     = scanEn;
    strobes.holdInactive = scanEn;
  end
endmodule

// File: rtl/reset_fanout_datapath.sv
module reset_fanout_datapath
  import reset_fanout_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int DEPTH     = 2
) (
  input  logic                 clk,
  input  logic                 rawRstN,
  input  logic                 scanIn,
  input  rfStrobes_t           strobes,
  output logic [NUM_UNITS-1:0] unitRstN,
  output logic                 scanOut
);
  localparam int SYNC_LEN  = 2;
  localparam int FIRST_REP = SYNC_LEN;
  localparam int CHAIN_LEN = SYNC_LEN + NUM_UNITS * DEPTH;

  logic [CHAIN_LEN-1:0] chainQ;
  logic [CHAIN_LEN-1:0] funcD;
  logic [CHAIN_LEN-1:0] scanD;
  logic [CHAIN_LEN-1:0] nextQ;

  // Functional next state: constant high into the synchronizer, then
  // each repeater branch starts from the synchronizer output.
  always_comb begin
    funcD[0] = 1'b1;
    for (int p = 1; p < CHAIN_LEN; p++) begin
      funcD[p] = chainQ[p-1];
    end
    for (int b = 0; b < NUM_UNITS; b++) begin
      funcD[FIRST_REP + b*DEPTH] = chainQ[SYNC_LEN-1];
    end
  end

  assign scanD = {chainQ[CHAIN_LEN-2:0], scanIn};
  assign nextQ = strobes.shiftSel ? scanD : funcD;

  always_ff @(posedge clk or negedge rawRstN) begin
    if (!rawRstN) chainQ <= '0;
    else          chainQ <= nextQ;
  end

  assign scanOut = chainQ[CHAIN_LEN-1];

  // R1: synchronizer second stage only rises after the first stage was high
  a_r1_sync_order: assert property (@(posedge clk) disable iff (!rawRstN)
    ($past(rawRstN) && !$past(strobes.shiftSel) && $rose(chainQ[1]))
      |-> $past(chainQ[0]));

  // R5: in shift, scan-out carries the previous content of the cell before it
  a_r5_chain_tail: assert property (@(posedge clk) disable iff (!rawRstN)
    ($past(rawRstN) && $past(strobes.shiftSel))
      |-> (scanOut == $past(chainQ[CHAIN_LEN-2])));

  for (genvar b = 0; b < NUM_UNITS; b++) begin : g_unit
    localparam int LAST = FIRST_REP + b*DEPTH + DEPTH - 1;
    localparam int PREV = (DEPTH > 1) ? LAST - 1 : SYNC_LEN - 1;

    assign unitRstN[b] = chainQ[LAST] | strobes.holdInactive;

    // R4: the release at a branch end is carried from its predecessor stage
    a_r4_ripple_stage: assert property (@(posedge clk) disable iff (!rawRstN)
      ($past(rawRstN) && !$past(strobes.shiftSel) && $rose(chainQ[LAST]))
        |-> $past(chainQ[PREV]));
  end
endmodule

// File: rtl/reset_fanout.sv
module reset_fanout
  import reset_fanout_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int DEPTH     = 2
) (
  input  logic                 clk,
  input  logic                 rstInN,
  input  logic                 scanEn,
  input  logic                 scanIn,
  output logic [NUM_UNITS-1:0] unitRstN,
  output logic                 scanOut
);
  rfStrobes_t strobes;

  reset_fanout_ctrl u_ctrl (
    .scanEn  (scanEn),
    .strobes (strobes)
  );

  reset_fanout_datapath #(
    .NUM_UNITS (NUM_UNITS),
    .DEPTH     (DEPTH)
  ) u_dp (
    .clk      (clk),
    .rawRstN  (rstInN),
    .scanIn   (scanIn),
    .strobes  (strobes),
    .unitRstN (unitRstN),
    .scanOut  (scanOut)
  );

  // R2: raw reset low in functional mode keeps every unit in reset
  a_r2_async_hold: assert property (@(negedge clk) disable iff (scanEn === 1'b1)
    (rstInN === 1'b0) |-> (unitRstN == '0));

  // R3: during shift no unit sees an active reset
  a_r3_shift_inactive: assert property (@(negedge clk) disable iff (!rstInN)
    $past(scanEn) && scanEn |-> (&unitRstN));
endmodule

// File: tb/reset_fanout_bench.sv
module reset_fanout_bench;
  localparam int NU  = 4;
  localparam int DP  = 2;
  localparam int LEN = 2 + NU*DP;
  localparam int NSH = 2*LEN;

  logic clk = 1'b0;
  logic rstInN, scanEn, scanIn;
  logic [NU-1:0] unitRstN;
  logic scanOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  logic sent [0:63];

  always #4 clk = ~clk;

  reset_fanout #(.NUM_UNITS(NU), .DEPTH(DP)) u_reset_fanout (
    .clk(clk), .rstInN(rstInN), .scanEn(scanEn), .scanIn(scanIn),
    .unitRstN(unitRstN), .scanOut(scanOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic patBit(input int pat, input int i);
    case (pat)
      0: return logic'(i % 2);
      1: return logic'(i % 3 == 0);
      default: return logic'(((i*7 + 3) % 5) < 2);
    endcase
  endfunction

  task automatic releaseAndCheck();
    @(negedge clk);
    rstInN = 1'b1;
    for (int e = 1; e <= DP + 3; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (e < 2 + DP) begin
        check(unitRstN == '0, (e <= 2) ? "R1 early release" : "R4 early release",
              unitRstN, 0);
      end else begin
        check(unitRstN == {NU{1'b1}}, "R4 release latency", unitRstN, {NU{1'b1}});
      end
    end
  endtask

  initial begin
    rstInN = 1'b0;
    scanEn = 1'b0;
    scanIn = 1'b0;
    repeat (3) @(negedge clk);
    check(unitRstN == '0, "R2 reset state", unitRstN, 0);
    check(scanOut == 1'b0, "R5 reset chain", scanOut, 0);

    // Release, then asynchronous re-assertion at several phases
    for (int k = 0; k < 3; k++) begin
      releaseAndCheck();
      @(negedge clk);
      #(1 + k);
      rstInN = 1'b0;
      #1;
      check(unitRstN == '0, "R2 async assert", unitRstN, 0);
      repeat (2) @(negedge clk);
    end

    // Shift with raw reset still low
    scanEn = 1'b1;
    #1;
    check(unitRstN == {NU{1'b1}}, "R3 gate over reset", unitRstN, {NU{1'b1}});
    @(negedge clk);
    rstInN = 1'b1;

    for (int pat = 0; pat < 3; pat++) begin
      for (int i = 1; i <= NSH; i++) begin
        scanIn = patBit(pat, i);
        sent[i] = scanIn;
        @(posedge clk);
        @(negedge clk);
        check(unitRstN == {NU{1'b1}}, "R3 shift inactive", unitRstN, {NU{1'b1}});
        if (i >= LEN) begin
          check(scanOut == sent[i-LEN+1], "R5 scan order", scanOut, sent[i-LEN+1]);
        end
      end
    end

    // Capture: after NSH shifts, cell p holds sent[NSH-p]
    scanEn = 1'b0;
    #1;
    for (int b = 0; b < NU; b++) begin
      check(unitRstN[b] == sent[NSH - (2 + b*DP + DP - 1)], "R6 capture pass",
            unitRstN[b], sent[NSH - (2 + b*DP + DP - 1)]);
    end
    @(posedge clk);
    @(negedge clk);
    for (int b = 0; b < NU; b++) begin
      logic expB;
      expB = (DP > 1) ? sent[NSH - (2 + b*DP + DP - 2)] : sent[NSH - 1];
      check(unitRstN[b] == expB, "R6 capture step", unitRstN[b], expB);
    end
    scanEn = 1'b1;
    #1;
    check(unitRstN == {NU{1'b1}}, "R3 back to shift", unitRstN, {NU{1'b1}});

    // Final functional reset cycle
    @(negedge clk);
    scanEn = 1'b0;
    rstInN = 1'b0;
    #1;
    check(unitRstN == '0, "R2 async assert final", unitRstN, 0);
    repeat (2) @(negedge clk);
    releaseAndCheck();

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog R4 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule